// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps time of day and calendar date as packed BCD digits. It puts them in the eight highest byte addresses of a byte-wide memory space. A host reaches these eight bytes with the same chip-select, write-strobe and output-enable cycles it uses for ordinary RAM. The block raises `clk_sel` so that the surrounding RAM array stays off the data bus for those addresses.

A set of live counters advances once per one-hertz pulse. It counts seconds, minutes, 24-hour hours, day of week, date, month, year and century, with leap years handled. The host never reads the live counters directly. It reads a second copy of them, which is refreshed after every advance.

The control byte holds two hold bits:
- The read-hold bit freezes the copy so the host can read a consistent snapshot while the live counters keep running.
- The write-hold bit also freezes the copy and lets the host overwrite the time bytes. Clearing it commits the staged values into the live counters.

Top module: `bcd_calendar_regs`

## Requirements
- R1: After reset the clock reads 2000-01-01, day of week 1, 00:00:00, with century 0x20 and both hold bits clear.
- R2: An access is a clock access only when address bits above bit 2 are all ones, and `clk_sel` is high exactly then. Offset 0 is the control byte: bit 7 is the write-hold bit, bit 6 is the read-hold bit and bits 5:0 are the BCD century. Offsets 1 to 7 are seconds, minutes, hours, day of week, date, month and year. Read data appears on the clock edge that samples the read, and is 0x00 for any read that is not a clock access.
- R3: Seconds and minutes each count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R4: Hours count 00 to 23. The wrap from 23 to 00 advances both the date and the day of week, and the day of week cycles 1 to 7 and back to 1.
- R5: The date wraps to 01 after the last day of the month, which is 30 for April, June, September and November, 31 for the other months, and 28 or 29 for February. The month wraps from 12 to 01 and increments the year.
- R6: February has 29 days when the full year is divisible by 4, unless it is divisible by 100 and not by 400. So 2000 and 2024 are leap years, and 2023 and 2100 are not.
- R7: The year wraps from 99 to 00 and increments the century.
- R8: With both hold bits clear, the readable copy takes the new counter value one clock after the edge at which the counters advance.
- R9: While the read-hold bit is set, the readable copy does not change, but the live counters keep counting. Clearing the bit reloads the copy from the counters one clock after the clearing write.
- R10: While the write-hold bit is set, the copy is frozen and host writes to offsets 1 to 7 and to the century field are accepted. A write that clears the bit loads the staged values into the live counters on the next edge, and counting resumes from them.
- R11: A write while the write-hold bit is clear changes only the two hold bits. Time bytes and century keep their values.
- R12: A one-hertz pulse that arrives while chip select is active is held back and not lost. The counters never change during an active chip select and advance exactly once after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for clock addresses |
| clk_sel | output | 1 | High while the address falls in the clock window |

## Verification
The bench runs its own arithmetic calendar model and compares against it. The timing it relies on:

| Event | When the result is visible |
|---|---|
| Read | `rdata` is valid one edge after the read is driven, and the bench samples it at the following falling edge. |
| One-hertz pulse | The live counters move at the edge that samples the pulse, and the readable copy moves one edge later. The bench waits three idle cycles before a snapshot, reads once right after the pulse edge to see the old value, and reads once more to see the new one. |
| Clearing a hold bit | The bit clears at the edge of the write. The commit or reload follows on the next edge, so the bench always leaves at least one idle cycle before checking. |

// File: rtl/rtc_cal_pkg.sv
// Package: shared types and BCD calendar arithmetic for the clock register bank.
// Assumes every stored value is valid packed BCD (two 4-bit digits).
package rtc_cal_pkg;

    localparam int BYTE_W = 8;
    localparam int NF     = 8;   // live fields: sec,min,hour,dow,date,month,year,century
    localparam int OFF_W  = 3;   // offset bits inside the clock window

    typedef logic [BYTE_W-1:0] bcd8_t;

    // Field indices into the live and user arrays
    localparam int FI_SEC  = 0;
    localparam int FI_MIN  = 1;
    localparam int FI_HOUR = 2;
    localparam int FI_DOW  = 3;
    localparam int FI_DATE = 4;
    localparam int FI_MON  = 5;
    localparam int FI_YEAR = 6;
    localparam int FI_CEN  = 7;

    // Increment a two-digit BCD value
    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Convert a two-digit BCD value to binary 0..99
    function automatic logic [6:0] bcd_to_bin(bcd8_t v);
        return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
    endfunction

    // Leap rule over century and year digits
    function automatic logic is_leap(bcd8_t cen, bcd8_t yr);
        logic [6:0] yb;
        logic [6:0] cb;
        yb = bcd_to_bin(yr);
        cb = bcd_to_bin(cen);
        return (yb[1:0] == 2'b00) && ((yb != 7'd0) || (cb[1:0] == 2'b00));
    endfunction

    // Last date of a month, in BCD
    function automatic bcd8_t month_last(bcd8_t mon, logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Reset value of each live field
    function automatic bcd8_t field_rst(int idx);
        case (idx)
            FI_DOW, FI_DATE, FI_MON: return 8'h01;
            FI_CEN:                  return 8'h20;
            default:                 return 8'h00;
        endcase
    endfunction

    // Value a field takes after passing its top
    function automatic bcd8_t field_wrap(int idx);
        case (idx)
            FI_DOW, FI_DATE, FI_MON: return 8'h01;
            default:                 return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/bcd_field_cnt.sv
// Module: one BCD field of the counting chain.
// Counts up on inc, wraps to WRAP_VAL past top, loads ld_val on load.
// Assumes top is valid BCD; values at or above top wrap.
module bcd_field_cnt
    import rtc_cal_pkg::*;
#(
    parameter bcd8_t RST_VAL  = 8'h00,
    parameter bcd8_t WRAP_VAL = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inc,
    input  logic  load,
    input  bcd8_t ld_val,
    input  bcd8_t top,
    output bcd8_t val,
    output logic  carry
);

    logic at_top;

    // Detect the last value of this field's range
    always_comb at_top = (val >= top);

    // Carry out when this field wraps
    always_comb carry = inc && at_top;

    // Field register: reset, load from host, or count
    always_ff @(posedge clk) begin
        if (!rst_n)      val <= RST_VAL;
        else if (load)   val <= ld_val;
        else if (inc)    val <= at_top ? WRAP_VAL : bcd_inc(val);
    end

endmodule

// File: rtl/rtc_count_chain.sv
// Module: live counting chain with tick deferral.
// A tick arriving while busy (bus active) or during a commit is held and
// applied at the first free cycle. commit loads all fields from ld_vals.
module rtc_count_chain
    import rtc_cal_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            busy,
    input  logic            commit,
    input  bcd8_t [NF-1:0]  ld_vals,
    output bcd8_t [NF-1:0]  vals,
    output logic            stepped
);

    logic           pend_q;
    logic           want;
    logic           leap;
    bcd8_t [NF-1:0] tops;
    logic  [NF-1:0] inc;
    logic  [NF-1:0] carry;

    // Decide whether the chain advances this cycle
    always_comb begin
        want    = tick || pend_q;
        stepped = want && !busy && !commit;
    end

    // Hold a tick that could not be applied yet
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= want && !stepped;
    end

    // Range top of each field; the date top follows month and leap year
    always_comb begin
        leap          = is_leap(vals[FI_CEN], vals[FI_YEAR]);
        tops[FI_SEC]  = 8'h59;
        tops[FI_MIN]  = 8'h59;
        tops[FI_HOUR] = 8'h23;
        tops[FI_DOW]  = 8'h07;
        tops[FI_DATE] = month_last(vals[FI_MON], leap);
        tops[FI_MON]  = 8'h12;
        tops[FI_YEAR] = 8'h99;
        tops[FI_CEN]  = 8'h39;
    end

    // Carry routing: the hour wrap feeds both day of week and date
    always_comb begin
        inc[FI_SEC]  = stepped;
        inc[FI_MIN]  = carry[FI_SEC];
        inc[FI_HOUR] = carry[FI_MIN];
        inc[FI_DOW]  = carry[FI_HOUR];
        inc[FI_DATE] = carry[FI_HOUR];
        inc[FI_MON]  = carry[FI_DATE];
        inc[FI_YEAR] = carry[FI_MON];
        inc[FI_CEN]  = carry[FI_YEAR];
    end

    for (genvar g = 0; g < NF; g++) begin : g_field
        bcd_field_cnt #(
            .RST_VAL  (field_rst(g)),
            .WRAP_VAL (field_wrap(g))
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc[g]),
            .load   (commit),
            .ld_val (ld_vals[g]),
            .top    (tops[g]),
            .val    (vals[g]),
            .carry  (carry[g])
        );
    end

endmodule

// File: rtl/rtc_host_regs.sv
// Module: host-visible register copy, hold bits and read path.
// Offset 0 is control (bit7 write-hold, bit6 read-hold, 5:0 century);
// offsets 1..7 map to live fields 0..6. acc means a clock-window access.
module rtc_host_regs
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             wr,
    input  logic             rd,
    input  logic [OFF_W-1:0] off,
    input  bcd8_t            wdata,
    input  bcd8_t [NF-1:0]   live,
    input  logic             stepped,
    output bcd8_t [NF-1:0]   user,
    output logic             wbit,
    output logic             rbit,
    output logic             commit,
    output logic             copy,
    output bcd8_t            rdata
);

    logic wr_acc;
    logic rd_acc;
    logic wr_ctrl;
    logic upd_q;
    logic reload_q;

    // Classify the current bus cycle
    always_comb begin
        wr_acc  = acc && wr;
        rd_acc  = acc && rd;
        wr_ctrl = wr_acc && (off == '0);
    end

    // Copy from the live counters when a refresh is due and no hold is set
    always_comb copy = (upd_q || reload_q) && !wbit && !rbit;

    // Hold bits follow every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbit <= 1'b0;
            rbit <= 1'b0;
        end else if (wr_ctrl) begin
            wbit <= wdata[7];
            rbit <= wdata[6];
        end
    end

    // Remember refresh, reload and commit requests for the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q    <= 1'b0;
            reload_q <= 1'b0;
            commit   <= 1'b0;
        end else begin
            upd_q    <= stepped;
            reload_q <= wr_ctrl && rbit && !wdata[6];
            commit   <= wr_ctrl && wbit && !wdata[7];
        end
    end

    // Host-visible copy: refresh from counters, or staged host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) user[i] <= field_rst(i);
        end else if (copy) begin
            user <= live;
        end else if (wr_acc && wbit) begin
            if (off == '0) user[FI_CEN] <= {2'b00, wdata[5:0]};
            else           user[off - 3'd1] <= wdata;
        end
    end

    // Registered read path
    always_ff @(posedge clk) begin
        if (!rst_n)           rdata <= '0;
        else if (!rd_acc)     rdata <= '0;
        else if (off == '0)   rdata <= {wbit, rbit, user[FI_CEN][5:0]};
        else                  rdata <= user[off - 3'd1];
    end

endmodule

// File: rtl/bcd_calendar_regs.sv
// Module: top of the BCD calendar clock register bank.
// Decodes the eight highest addresses as clock bytes and links the live
// counting chain to the host-visible copy. Assumes a synchronous bus
// sampled on clk; tick_1hz is a one-cycle pulse.
module bcd_calendar_regs
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              clk_sel
);

    localparam int HI_W = ADDR_W - OFF_W;

    logic             acc;
    logic             wr_en;
    logic             rd_en;
    logic [OFF_W-1:0] off;
    bcd8_t [NF-1:0]   live;
    bcd8_t [NF-1:0]   user;
    logic             wbit;
    logic             rbit;
    logic             commit;
    logic             copy;
    logic             stepped;

    // Address decode and strobe qualification
    always_comb begin
        clk_sel = (addr[ADDR_W-1:OFF_W] == {HI_W{1'b1}});
        off     = addr[OFF_W-1:0];
        acc     = !ce_n && clk_sel;
        wr_en   = !we_n;
        rd_en   = !oe_n && we_n;
    end

    rtc_count_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .busy    (!ce_n),
        .commit  (commit),
        .ld_vals (user),
        .vals    (live),
        .stepped (stepped)
    );

    rtc_host_regs u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .wr      (wr_en),
        .rd      (rd_en),
        .off     (off),
        .wdata   (wdata),
        .live    (live),
        .stepped (stepped),
        .user    (user),
        .wbit    (wbit),
        .rbit    (rbit),
        .commit  (commit),
        .copy    (copy),
        .rdata   (rdata)
    );

endmodule

// File: rtl/rtc_regs_chk.sv
// Checker: temporal properties of the calendar register bank, bound to the top.
module rtc_regs_chk
    import rtc_cal_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             acc,
    input logic             wr_en,
    input logic [OFF_W-1:0] off,
    input logic             wbit,
    input logic             rbit,
    input logic             commit,
    input logic             copy,
    input logic             stepped,
    input bcd8_t [NF-1:0]   live,
    input bcd8_t [NF-1:0]   user
);

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stepped && live[FI_SEC] == 8'h59) |=> (live[FI_SEC] == 8'h00)); // R3

    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stepped && live[FI_SEC] == 8'h59 && live[FI_MIN] == 8'h59 && live[FI_HOUR] == 8'h23)
        |=> (live[FI_HOUR] == 8'h00)); // R4

    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stepped && live[FI_SEC] == 8'h59 && live[FI_MIN] == 8'h59 && live[FI_HOUR] == 8'h23
         && live[FI_DOW] == 8'h07) |=> (live[FI_DOW] == 8'h01)); // R4

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !commit) |=> $stable(live)); // R12

    AST_READ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (rbit && !wbit) |=> $stable(user)); // R9

    AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wbit) |=> (live == $past(user))); // R10

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_en && !wbit && off != '0 && !copy) |=> $stable(user)); // R11

endmodule

bind bcd_calendar_regs rtc_regs_chk i_rtc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .acc     (acc),
    .wr_en   (wr_en),
    .off     (off),
    .wbit    (wbit),
    .rbit    (rbit),
    .commit  (commit),
    .copy    (copy),
    .stepped (stepped),
    .live    (live),
    .user    (user)
);

// File: tb/test_bcd_calendar_regs.sv
// Bench: arithmetic calendar model against the register bank.
module test_bcd_calendar_regs;

    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1hz = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          clk_sel;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model (binary)
    int m_s, m_mi, m_h, m_dw, m_d, m_mo, m_y, m_c;

    bcd_calendar_regs #(.ADDR_W(AW)) i_bcd_calendar_regs (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .ce_n(ce_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .clk_sel(clk_sel)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [AW-1:0] caddr(int off);
        return {{(AW-3){1'b1}}, 3'(off)};
    endfunction

    function automatic int dim(int mo, int c, int y);
        int fy;
        bit lp;
        fy = c * 100 + y;
        lp = ((fy % 4 == 0) && (fy % 100 != 0)) || (fy % 400 == 0);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input int got, input int exp, input string req);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic m_advance();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_dw = (m_dw == 7) ? 1 : m_dw + 1;
                    m_d++;
                    if (m_d > dim(m_mo, m_c, m_y)) begin
                        m_d = 1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1; m_y++;
                            if (m_y == 100) begin m_y = 0; m_c++; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input int off, input logic [7:0] v);
        ce_n = 1'b0; we_n = 1'b0; addr = caddr(off); wdata = v;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd_byte(input int off, output logic [7:0] v);
        ce_n = 1'b0; oe_n = 1'b0; addr = caddr(off);
        @(negedge clk);
        v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic pulse();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        idle(3);
        m_advance();
    endtask

    // Snapshot with the read-hold bit and compare every byte
    task automatic read_all(input string req);
        logic [7:0] v;
        wr_byte(0, 8'h40);
        rd_byte(0, v); chk(v, 8'h40 | to_bcd(m_c), {req, " ctrl/century"});
        rd_byte(1, v); chk(v, to_bcd(m_s),  {req, " seconds"});
        rd_byte(2, v); chk(v, to_bcd(m_mi), {req, " minutes"});
        rd_byte(3, v); chk(v, to_bcd(m_h),  {req, " hours"});
        rd_byte(4, v); chk(v, to_bcd(m_dw), {req, " day of week"});
        rd_byte(5, v); chk(v, to_bcd(m_d),  {req, " date"});
        rd_byte(6, v); chk(v, to_bcd(m_mo), {req, " month"});
        rd_byte(7, v); chk(v, to_bcd(m_y),  {req, " year"});
        wr_byte(0, 8'h00);
        idle(2);
    endtask

    // Stage and commit a full time through the write-hold sequence (R10)
    task automatic set_time(input int c, input int y, input int mo, input int d,
                            input int dw, input int h, input int mi, input int s);
        wr_byte(0, 8'h80);
        wr_byte(1, to_bcd(s));
        wr_byte(2, to_bcd(mi));
        wr_byte(3, to_bcd(h));
        wr_byte(4, to_bcd(dw));
        wr_byte(5, to_bcd(d));
        wr_byte(6, to_bcd(mo));
        wr_byte(7, to_bcd(y));
        wr_byte(0, to_bcd(c) & 8'h3f);
        idle(3);
        m_c = c; m_y = y; m_mo = mo; m_d = d; m_dw = dw; m_h = h; m_mi = mi; m_s = s;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int yc [4];
        int yy [4];
        int cs;
        m_c = 20; m_y = 0; m_mo = 1; m_d = 1; m_dw = 1; m_h = 0; m_mi = 0; m_s = 0;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        read_all("R1");

        // R2: decode and non-clock reads
        ce_n = 1'b0; oe_n = 1'b0; addr = '0;
        #1 chk(clk_sel, 0, "R2 clk_sel low address");
        @(negedge clk);
        chk(rdata, 0, "R2 non-clock read data");
        addr = caddr(3);
        #1 chk(clk_sel, 1, "R2 clk_sel top address");
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        addr = {1'b0, {(AW-1){1'b1}}};
        #1 chk(clk_sel, 0, "R2 clk_sel msb clear");
        idle(2);

        // R8: refresh latency after a tick
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        rd_byte(1, v); chk(v, 8'h00, "R8 copy not yet refreshed");
        rd_byte(1, v); chk(v, 8'h01, "R8 copy refreshed next edge");
        m_advance();
        idle(2);

        // R9: read hold freezes copy, counters continue
        wr_byte(0, 8'h40);
        pulse(); pulse(); pulse();
        rd_byte(1, v); chk(v, 8'h01, "R9 seconds frozen under read hold");
        rd_byte(0, v); chk(v, 8'h60, "R9 control shows read hold");
        wr_byte(0, 8'h00);
        idle(1);
        rd_byte(1, v); chk(v, 8'h04, "R9 reload after clearing read hold");
        idle(2);

        // R11: writes with write hold clear are ignored for time fields
        wr_byte(1, 8'h33);
        wr_byte(2, 8'h44);
        wr_byte(7, 8'h55);
        wr_byte(0, 8'h15);
        idle(2);
        read_all("R11");

        // R12: tick during an active chip select is deferred, not lost
        ce_n = 1'b0; oe_n = 1'b0; addr = caddr(1); tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(rdata, to_bcd(m_s), "R12 no change during access");
            @(negedge clk);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        idle(3);
        m_advance();
        read_all("R12 single deferred advance");

        // R10: write hold freezes copy; commit overrides running counters
        wr_byte(0, 8'h80);
        rd_byte(1, v);
        tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0; idle(3);
        tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0; idle(3);
        rd_byte(1, v); chk(v, to_bcd(m_s), "R10 copy frozen under write hold");
        rd_byte(0, v); chk(v, 8'h80 | to_bcd(m_c), "R10 control shows write hold");
        wr_byte(1, 8'h45);
        wr_byte(3, 8'h12);
        wr_byte(0, 8'h21);
        idle(3);
        m_s = 45; m_h = 12; m_c = 21;
        read_all("R10 committed values");
        pulse();
        read_all("R10 counting resumes");

        // R3..R7: end-of-month rollover over every month of four years
        yc = '{20, 20, 21, 20};
        yy = '{23, 24, 0, 0};
        cs = 0;
        for (int k = 0; k < 4; k++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                set_time(yc[k], yy[k], mo, dim(mo, yc[k], yy[k]), (cs % 7) + 1, 23, 59, 59);
                cs++;
                pulse();
                read_all(mo == 2 ? "R6 February rollover" : "R5 month rollover");
            end
        end
        set_time(20, 99, 12, 31, 7, 23, 59, 59);
        pulse();
        read_all("R7 year 2099 to 2100");
        set_time(19, 99, 12, 31, 5, 23, 59, 59);
        pulse();
        read_all("R7 year 1999 to 2000");
        set_time(21, 0, 2, 28, 3, 23, 59, 59);
        pulse();
        read_all("R6 2100 is not leap");

        // R3, R4: long sweep of seconds/minutes/hours across leap day
        set_time(20, 24, 2, 28, 7, 23, 0, 0);
        for (int t = 1; t <= 3661; t++) begin
            pulse();
            if (t % 61 == 0) read_all("R3 R4 sweep");
        end
        read_all("R4 sweep end");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule